// File: doc/BRIEF.md
# Local Memory Read Steering Unit

This block sits between a processor's read and instruction-fetch port and four possible data sources: an on-chip SRAM, an on-chip ROM, a small instruction cache and external system memory. Each accepted request goes to every local source in the same cycle. One of them is then chosen by a fixed order: SRAM first, then ROM, then cache. When none of them holds the address, the block starts an external read and waits for it.

The SRAM and ROM regions each have a configuration value made of a base and a valid bit. A cleared valid bit masks the region. A masked region is never enabled, so it draws no lookup power, and it never answers. Data that comes back from external memory is offered to the direct-mapped cache for allocation. Data that comes from SRAM or ROM is never offered to it. The SRAM, ROM and cache storage are simple behavioural models.

The control path is a four-state machine. S_IDLE waits for a request. From S_IDLE, a request that any local source hits moves the machine to S_LOCAL, and a request that no local source hits moves it to S_EXT. S_LOCAL presents the response for one cycle and then returns to S_IDLE. S_EXT holds the external request and moves to S_FILL when external memory acknowledges. S_FILL presents the fetched word, signals cache allocation, and then returns to S_IDLE.

Top module: `lmem_read_steer`

## Requirements
- R1: A request is accepted only when `req_valid` is high in S_IDLE. In that cycle `cache_en` is high, and the SRAM and ROM enables are evaluated in the same cycle. A request offered in any other state is ignored: all three enables stay low and `ext_addr` does not change.
- R2: If the address hits the SRAM region, the response carries SRAM data, and any ROM or cache hit for that access is discarded. The SRAM model returns the word `{zero-extended addr} ^ 32'h5A5A_0000`.
- R3: If the SRAM misses and the ROM region hits, the response carries ROM data, and any cache hit is discarded. The ROM model returns `{zero-extended addr} ^ 32'hC3C3_0000`.
- R4: If both regions miss and the cache hits, the response carries the cached word. The cache is direct-mapped with 8 one-word lines. It is indexed by `addr[2:0]` and tagged with `addr[9:3]`, and it is empty after reset.
- R5: If no local source hits, `ext_req` rises in the cycle after acceptance with `ext_addr` equal to the request address. Both hold until `ext_ack` is sampled high. In the next cycle `rsp_ready` is high and `rsp_data` equals the `ext_data` sampled with the acknowledge.
- R6: `cache_alloc` pulses for one cycle together with `rsp_ready` only when the response comes from external memory, and the cache then stores that word. It is never high for an SRAM, ROM or cache response.
- R7: `sram_en` is high only in an accepting cycle where the SRAM valid bit is set and the address matches. `rom_en` follows the same rule for the ROM. A masked region's enable stays low even when the address matches its base.
- R8: The SRAM region is a hit when its valid bit is set and `addr[9:6]` equals `sram_base`. The ROM region is a hit when its valid bit is set and `addr[9:8]` equals `rom_base`. Overlapping regions resolve by the order in R2 and R3.
- R9: For an SRAM, ROM or cache hit, `rsp_ready` is high for exactly the one cycle after acceptance. `ext_req` stays low throughout.
- R10: After reset, `rsp_ready`, `ext_req`, `cache_alloc` and all three enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read or fetch request strobe |
| req_addr | input | 10 | Word address of the request |
| sram_base | input | 4 | SRAM region base (address bits above the region size) |
| sram_valid | input | 1 | SRAM region enable; low masks the region |
| rom_base | input | 2 | ROM region base (address bits above the region size) |
| rom_valid | input | 1 | ROM region enable; low masks the region |
| sram_en | output | 1 | SRAM lookup activation |
| rom_en | output | 1 | ROM lookup activation |
| cache_en | output | 1 | Cache lookup activation |
| rsp_ready | output | 1 | Response data valid |
| rsp_data | output | 32 | Response data |
| ext_req | output | 1 | External memory read request |
| ext_addr | output | 10 | External read address |
| ext_ack | input | 1 | External memory acknowledge |
| ext_data | input | 32 | External read data, valid with ext_ack |
| cache_alloc | output | 1 | Fetched line offered to the cache |

## Verification
The lookup enables are combinational, so they are sampled in the accepting cycle itself. A local response is due one clock after acceptance and must be gone one clock after that. An external request must be visible one clock after acceptance and stay unchanged through a random-length wait. The filled response and the allocate pulse are due one clock after the acknowledge. The bench drives every input on the falling edge and samples at each of these points. It sweeps every address twice under five region configurations, including masked and overlapping ones, and it predicts the source of each access from its own model of the regions and the cache.

// File: rtl/lmem_pkg.sv
package lmem_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LOCAL = 2'd1,
        S_EXT   = 2'd2,
        S_FILL  = 2'd3
    } steer_state_t;

    typedef enum logic [1:0] {
        SRC_SRAM  = 2'd0,
        SRC_ROM   = 2'd1,
        SRC_CACHE = 2'd2,
        SRC_EXT   = 2'd3
    } steer_src_t;
endpackage

// File: rtl/lmem_region_decode.sv
module lmem_region_decode #(
    parameter int AW      = 10,
    parameter int SZ_LOG2 = 6,
    localparam int BW     = AW - SZ_LOG2
) (
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] base,
    input  logic          valid,
    output logic          hit
);
    always_comb begin
        hit = valid && (addr[AW-1:SZ_LOG2] == base);
    end
endmodule

// File: rtl/lmem_word_store.sv
module lmem_word_store #(
    parameter int          AW   = 10,
    parameter int          DW   = 32,
    parameter logic [31:0] SEED = 32'h0
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    // Behavioural content: a fixed function of the address, read when enabled.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= {{(DW-AW){1'b0}}, rd_addr} ^ DW'(SEED);
        end
    end
endmodule

// File: rtl/lmem_icache_model.sv
module lmem_icache_model #(
    parameter int AW    = 10,
    parameter int DW    = 32,
    parameter int LINES = 8,
    localparam int IW   = $clog2(LINES),
    localparam int TW   = AW - IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_en,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data,
    input  logic          fill_we,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data
);
    logic [LINES-1:0] line_valid;
    logic [TW-1:0]    line_tag  [LINES];
    logic [DW-1:0]    line_word [LINES];

    logic [IW-1:0] lk_idx;
    logic [IW-1:0] fill_idx;

    always_comb begin
        lk_idx   = lk_addr[IW-1:0];
        fill_idx = fill_addr[IW-1:0];
        lk_hit   = line_valid[lk_idx] && (line_tag[lk_idx] == lk_addr[AW-1:IW]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_valid <= '0;
        end else if (fill_we) begin
            line_valid[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            line_tag[fill_idx]  <= fill_addr[AW-1:IW];
            line_word[fill_idx] <= fill_data;
        end
        if (lk_en) begin
            lk_data <= line_word[lk_idx];
        end
    end
endmodule

// File: rtl/lmem_read_steer.sv
module lmem_read_steer
    import lmem_pkg::*;
#(
    parameter int AW        = 10,
    parameter int DW        = 32,
    parameter int SRAM_LOG2 = 6,
    parameter int ROM_LOG2  = 8,
    parameter int LINES     = 8,
    localparam int SBW      = AW - SRAM_LOG2,
    localparam int RBW      = AW - ROM_LOG2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic [SBW-1:0] sram_base,
    input  logic           sram_valid,
    input  logic [RBW-1:0] rom_base,
    input  logic           rom_valid,
    output logic           sram_en,
    output logic           rom_en,
    output logic           cache_en,
    output logic           rsp_ready,
    output logic [DW-1:0]  rsp_data,
    output logic           ext_req,
    output logic [AW-1:0]  ext_addr,
    input  logic           ext_ack,
    input  logic [DW-1:0]  ext_data,
    output logic           cache_alloc
);
    steer_state_t state, state_nx;
    steer_src_t   src_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] fill_q;

    logic accept;
    logic sram_hit, rom_hit, cache_hit;
    logic [DW-1:0] sram_rd, rom_rd, cache_rd;

    assign accept = req_valid && (state == S_IDLE);

    lmem_region_decode #(.AW(AW), .SZ_LOG2(SRAM_LOG2)) u_sram_dec (
        .addr(req_addr), .base(sram_base), .valid(sram_valid), .hit(sram_hit)
    );
    lmem_region_decode #(.AW(AW), .SZ_LOG2(ROM_LOG2)) u_rom_dec (
        .addr(req_addr), .base(rom_base), .valid(rom_valid), .hit(rom_hit)
    );

    lmem_word_store #(.AW(AW), .DW(DW), .SEED(32'h5A5A_0000)) u_sram (
        .clk(clk), .rd_en(sram_en), .rd_addr(req_addr), .rd_data(sram_rd)
    );
    lmem_word_store #(.AW(AW), .DW(DW), .SEED(32'hC3C3_0000)) u_rom (
        .clk(clk), .rd_en(rom_en), .rd_addr(req_addr), .rd_data(rom_rd)
    );

    lmem_icache_model #(.AW(AW), .DW(DW), .LINES(LINES)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_en(cache_en), .lk_addr(req_addr), .lk_hit(cache_hit), .lk_data(cache_rd),
        .fill_we(cache_alloc), .fill_addr(addr_q), .fill_data(fill_q)
    );

    // Lookup activation: all sources in the accepting cycle, masked regions never.
    always_comb begin
        cache_en = accept;
        sram_en  = accept && sram_hit;
        rom_en   = accept && rom_hit;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept) state_nx = (sram_hit || rom_hit || cache_hit) ? S_LOCAL : S_EXT;
            S_LOCAL: state_nx = S_IDLE;
            S_EXT:   if (ext_ack) state_nx = S_FILL;
            S_FILL:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register plus per-request captures.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            src_q  <= SRC_EXT;
            addr_q <= '0;
            fill_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                addr_q <= req_addr;
                if (sram_hit)       src_q <= SRC_SRAM;
                else if (rom_hit)   src_q <= SRC_ROM;
                else if (cache_hit) src_q <= SRC_CACHE;
                else                src_q <= SRC_EXT;
            end
            if (state == S_EXT && ext_ack) begin
                fill_q <= ext_data;
            end
        end
    end

    // Outputs.
    always_comb begin
        rsp_ready   = 1'b0;
        rsp_data    = '0;
        ext_req     = 1'b0;
        cache_alloc = 1'b0;
        ext_addr    = addr_q;
        unique case (state)
            S_IDLE: ;
            S_LOCAL: begin
                rsp_ready = 1'b1;
                unique case (src_q)
                    SRC_SRAM:  rsp_data = sram_rd;
                    SRC_ROM:   rsp_data = rom_rd;
                    SRC_CACHE: rsp_data = cache_rd;
                    default:   rsp_data = '0;
                endcase
            end
            S_EXT: ext_req = 1'b1;
            S_FILL: begin
                rsp_ready   = 1'b1;
                rsp_data    = fill_q;
                cache_alloc = 1'b1;
            end
            default: ;
        endcase
    end

    // Assertions.
    p_one_lookup_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en || rom_en) |-> cache_en);
    p_sram_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |=> (rsp_ready && rsp_data == sram_rd));
    p_rom_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en && !sram_en) |=> (rsp_ready && rsp_data == rom_rd));
    p_ext_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)));
    p_alloc_after_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cache_alloc |-> $past(ext_req && ext_ack));
    p_masked_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en |-> sram_valid) and (rom_en |-> rom_valid));
    p_local_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_en && (sram_hit || rom_hit || cache_hit)) |=> (rsp_ready && !ext_req && !cache_alloc));
    p_busy_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req || rsp_ready) |-> !(cache_en || sram_en || rom_en));
endmodule

// File: tb/lmem_read_steer_tb.sv
module lmem_read_steer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [3:0]  sram_base = '0;
    logic        sram_valid = 1'b0;
    logic [1:0]  rom_base = '0;
    logic        rom_valid = 1'b0;
    logic        sram_en, rom_en, cache_en, rsp_ready, ext_req, cache_alloc;
    logic [31:0] rsp_data;
    logic [9:0]  ext_addr;
    logic        ext_ack = 1'b0;
    logic [31:0] ext_data = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic       m_valid [8];
    logic [6:0] m_tag   [8];
    logic [31:0] m_word [8];

    always #2.5 clk = ~clk;

    lmem_read_steer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .sram_base(sram_base), .sram_valid(sram_valid),
        .rom_base(rom_base), .rom_valid(rom_valid),
        .sram_en(sram_en), .rom_en(rom_en), .cache_en(cache_en),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .ext_req(ext_req), .ext_addr(ext_addr), .ext_ack(ext_ack), .ext_data(ext_data),
        .cache_alloc(cache_alloc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_access(input logic [9:0] a, input int delay);
        bit es, er, ec;
        logic [31:0] expd;
        logic [31:0] xd;
        es = sram_valid && (a[9:6] == sram_base);
        er = rom_valid && (a[9:8] == rom_base);
        ec = m_valid[a[2:0]] && (m_tag[a[2:0]] == a[9:3]);
        if (es)      expd = {22'b0, a} ^ 32'h5A5A_0000;
        else if (er) expd = {22'b0, a} ^ 32'hC3C3_0000;
        else         expd = m_word[a[2:0]];
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        chk(cache_en == 1'b1, "R1 cache_en on accept", 32'(cache_en), 32'd1);
        chk(sram_en == es, "R7/R8 sram_en", 32'(sram_en), 32'(es));
        chk(rom_en == er, "R7/R8 rom_en", 32'(rom_en), 32'(er));
        @(negedge clk);
        req_valid = 1'b0;
        if (es || er || ec) begin
            chk(rsp_ready == 1'b1, "R9 local ready", 32'(rsp_ready), 32'd1);
            chk(rsp_data == expd, es ? "R2 sram data" : (er ? "R3 rom data" : "R4 cache data"),
                rsp_data, expd);
            chk(ext_req == 1'b0, "R9 no ext_req", 32'(ext_req), 32'd0);
            chk(cache_alloc == 1'b0, "R6 no alloc on local", 32'(cache_alloc), 32'd0);
            @(negedge clk);
            chk(rsp_ready == 1'b0, "R9 one-cycle ready", 32'(rsp_ready), 32'd0);
        end else begin
            chk(ext_req == 1'b1, "R5 ext_req", 32'(ext_req), 32'd1);
            chk(ext_addr == a, "R5 ext_addr", 32'(ext_addr), 32'(a));
            chk(rsp_ready == 1'b0, "R5 not ready while waiting", 32'(rsp_ready), 32'd0);
            for (int w = 0; w < delay; w++) begin
                if (w == 0) begin
                    req_valid = 1'b1;
                    req_addr  = ~a;
                    #1;
                    chk(!(sram_en || rom_en || cache_en), "R1 busy request ignored",
                        {29'b0, sram_en, rom_en, cache_en}, 32'd0);
                end
                @(negedge clk);
                req_valid = 1'b0;
                chk(ext_req == 1'b1 && ext_addr == a, "R5 ext held", 32'(ext_addr), 32'(a));
            end
            xd = 32'hE7E7_0000 ^ {22'b0, a};
            ext_ack  = 1'b1;
            ext_data = xd;
            @(negedge clk);
            ext_ack  = 1'b0;
            ext_data = '0;
            chk(rsp_ready == 1'b1, "R5 fill ready", 32'(rsp_ready), 32'd1);
            chk(rsp_data == xd, "R5 fill data", rsp_data, xd);
            chk(cache_alloc == 1'b1, "R6 alloc on fill", 32'(cache_alloc), 32'd1);
            m_valid[a[2:0]] = 1'b1;
            m_tag[a[2:0]]   = a[9:3];
            m_word[a[2:0]]  = xd;
            @(negedge clk);
            chk(rsp_ready == 1'b0 && cache_alloc == 1'b0, "R6 alloc one cycle",
                {30'b0, rsp_ready, cache_alloc}, 32'd0);
        end
    endtask

    task automatic sweep(input bit sv, input logic [3:0] sb, input bit rv, input logic [1:0] rb);
        @(negedge clk);
        sram_valid = sv; sram_base = sb; rom_valid = rv; rom_base = rb;
        for (int a = 0; a < 1024; a++) begin
            do_access(10'(a), a % 4);
            do_access(10'(a), (a + 1) % 4);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_word[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk({rsp_ready, ext_req, cache_alloc, sram_en, rom_en, cache_en} == 6'b0,
            "R10 reset outputs", {26'b0, rsp_ready, ext_req, cache_alloc, sram_en, rom_en, cache_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rsp_ready, ext_req, cache_alloc} == 3'b0, "R10 idle after reset",
            {29'b0, rsp_ready, ext_req, cache_alloc}, 32'd0);
        sweep(1'b0, 4'd0, 1'b0, 2'd0);
        sweep(1'b1, 4'd3, 1'b0, 2'd0);
        sweep(1'b0, 4'd0, 1'b1, 2'd2);
        sweep(1'b1, 4'd9, 1'b1, 2'd2);
        sweep(1'b1, 4'd0, 1'b1, 2'd3);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule